// File: doc/BRIEF.md
# Unlock-Sequence Store/Recall Command Detector

This block sits beside a byte-wide memory and watches every access presented to it. A host that wants to move the memory contents into (or back from) nonvolatile backing storage issues six reads. The first five go to fixed key addresses in a fixed order. The sixth address selects one of four commands: store, recall, turn off automatic store on power loss, or turn it back on. Any stray access breaks the sequence. A stray read of the first key address is the only access that restarts it, and it counts as the first step again.

The block also keeps a dirty flag, which any accepted write sets. A store asked for by the hardware request pin or by a power-fail indication only runs when this flag is set. A store from the software sequence always runs. While a store or recall is running, the active-low busy output is held low and every access is refused. The length of each operation is a parameter, counted in clock cycles. A one-cycle done pulse marks the end of each operation. At reset the block performs a recall, as it would at power-up.

Top module: `nvop_sequencer`

## Requirements
- R1: Only address bits [13:0] are compared. Five reads in this order are the unlock keys: 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F. The sixth read then decodes as follows: 0x0FC0 starts a store, 0x0C63 starts a recall, 0x0B45 disables automatic store and 0x0B46 enables it.
- R2: Any of the following aborts the sequence and issues no command: a write at any step, a read of a wrong address during the prefix, or a sixth read that is not one of the four codes.
- R3: After an abort, an accepted read of 0x0E38 counts as the first key, so the next key completes step two.
- R4: A software store runs whether or not the dirty flag is set. busy_no goes low in the cycle after the sixth read is accepted and stays low for exactly STORE_CYCLES cycles.
- R5: A software recall holds busy_no low for exactly RECALL_CYCLES cycles.
- R6: dirty_o is set by any accepted write. It is cleared when a store or recall completes.
- R7: A high hw_store_req_i starts a store only while dirty_o is 1. Otherwise it has no effect.
- R8: auto_en_o is 1 after reset. A high pwr_fail_i starts a store only while auto_en_o is 1 and dirty_o is 1.
- R9: While busy_no is low, acc_ok_o is 0. A write presented during that time does not set dirty_o.
- R10: During reset busy_no is low. After reset is released, a recall holds busy_no low for RECALL_CYCLES cycles.
- R11: store_done_o or recall_done_o, whichever matches the finished operation, is high for exactly one cycle: the first cycle in which busy_no is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | One memory access is presented this cycle |
| acc_addr_i | input | ADDR_W | Access address |
| acc_we_i | input | 1 | 1 = write access, 0 = read access |
| hw_store_req_i | input | 1 | Hardware store request (level) |
| pwr_fail_i | input | 1 | Power-loss store request (level) |
| acc_ok_o | output | 1 | Presented access is accepted (not blocked) |
| busy_no | output | 1 | Low while a store or recall runs |
| store_done_o | output | 1 | One-cycle pulse at store completion |
| recall_done_o | output | 1 | One-cycle pulse at recall completion |
| dirty_o | output | 1 | A write has occurred since the last store or recall |
| auto_en_o | output | 1 | Automatic store on power loss is enabled |

## Verification
The sequence detector is driven with five kinds of input. The full key series followed by each of the four command codes shows that every code is decoded to the right action. A series broken by a foreign read or by a write shows that an abort really discards progress. A series broken by a repeated first key shows the restart-at-step-two rule, as distinct from a full reset to idle. Key addresses with bit 14 set show that the upper address bit is ignored. The hardware and power-fail requests are each applied with the dirty flag clear and then set, and the power-fail request is applied with automatic store both off and on. These cases separate a conditional store from an unconditional one. Busy widths are counted cycle by cycle so that an off-by-one in the duration counter is caught.

// File: rtl/nvop_pkg.sv
`timescale 1ns/1ps
package nvop_pkg;
  localparam int KEY_W    = 14;
  localparam int N_PREFIX = 5;

  localparam logic [KEY_W-1:0] CODE_STORE    = 14'h0FC0;
  localparam logic [KEY_W-1:0] CODE_RECALL   = 14'h0C63;
  localparam logic [KEY_W-1:0] CODE_AUTO_OFF = 14'h0B45;
  localparam logic [KEY_W-1:0] CODE_AUTO_ON  = 14'h0B46;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_STORE, CMD_RECALL, CMD_AUTO_OFF, CMD_AUTO_ON
  } cmd_e;

  typedef enum logic [1:0] {
    OP_IDLE, OP_STORE, OP_RECALL
  } op_e;

  function automatic logic [KEY_W-1:0] prefix_key(input int idx);
    case (idx)
      0:       prefix_key = 14'h0E38;
      1:       prefix_key = 14'h31C7;
      2:       prefix_key = 14'h03E0;
      3:       prefix_key = 14'h3C1F;
      4:       prefix_key = 14'h303F;
      default: prefix_key = '0;
    endcase
  endfunction
endpackage

// File: rtl/nvop_seq_match.sv
`timescale 1ns/1ps
module nvop_seq_match
  import nvop_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output cmd_e              cmd_o
);
  localparam int STEP_W = $clog2(N_PREFIX + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_PREFIX);

  logic [KEY_W-1:0]    key;
  logic [N_PREFIX-1:0] pre_hit;
  logic [STEP_W-1:0]   step_q, step_d;
  logic                restart, step_hit;
  logic                unused_hi;

  assign key       = addr_i[KEY_W-1:0];
  assign unused_hi = ^addr_i;

  for (genvar g = 0; g < N_PREFIX; g++) begin : g_key
    assign pre_hit[g] = (key == prefix_key(g));
  end

  assign restart = !we_i && pre_hit[0];

  always_comb begin
    step_hit = 1'b0;
    for (int i = 0; i < N_PREFIX; i++)
      if (step_q == STEP_W'(i)) step_hit = pre_hit[i];
  end

  always_comb begin
    step_d = step_q;
    cmd_o  = CMD_NONE;
    if (fire_i) begin
      // abort path; a read of the first key counts as step one
      step_d = restart ? STEP_W'(1) : '0;
      if (step_q == LAST_STEP) begin
        if (!we_i) begin
          unique case (key)
            CODE_STORE:    begin cmd_o = CMD_STORE;    step_d = '0; end
            CODE_RECALL:   begin cmd_o = CMD_RECALL;   step_d = '0; end
            CODE_AUTO_OFF: begin cmd_o = CMD_AUTO_OFF; step_d = '0; end
            CODE_AUTO_ON:  begin cmd_o = CMD_AUTO_ON;  step_d = '0; end
            default: ;
          endcase
        end
      end else if (!we_i && step_hit) begin
        step_d = step_q + STEP_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else         step_q <= step_d;
  end
endmodule

// File: rtl/nvop_timer.sv
`timescale 1ns/1ps
module nvop_timer #(
  parameter int           CNT_W   = 6,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= RST_VAL;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nvop_sequencer.sv
`timescale 1ns/1ps
module nvop_sequencer
  import nvop_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int STORE_CYCLES  = 40,
  parameter int RECALL_CYCLES = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_we_i,
  input  logic              hw_store_req_i,
  input  logic              pwr_fail_i,
  output logic              acc_ok_o,
  output logic              busy_no,
  output logic              store_done_o,
  output logic              recall_done_o,
  output logic              dirty_o,
  output logic              auto_en_o
);
  localparam int MAX_CYC = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] STORE_LD  = CNT_W'(STORE_CYCLES - 1);
  localparam logic [CNT_W-1:0] RECALL_LD = CNT_W'(RECALL_CYCLES - 1);

  op_e  op_q, op_d;
  cmd_e cmd;
  logic busy, fire, finish, zero;
  logic start_store, start_recall;
  logic dirty_q, auto_en_q, sdone_q, rdone_q;

  assign busy = (op_q != OP_IDLE);
  assign fire = acc_valid_i && !busy;

  nvop_seq_match #(.ADDR_W(ADDR_W)) i_match (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .we_i   (acc_we_i),
    .addr_i (acc_addr_i),
    .cmd_o  (cmd)
  );

  // priority: power loss, hardware request, software command
  always_comb begin
    start_store  = 1'b0;
    start_recall = 1'b0;
    if (!busy) begin
      if (pwr_fail_i && auto_en_q && dirty_q)  start_store  = 1'b1;
      else if (hw_store_req_i && dirty_q)      start_store  = 1'b1;
      else if (cmd == CMD_STORE)               start_store  = 1'b1;
      else if (cmd == CMD_RECALL)              start_recall = 1'b1;
    end
  end

  nvop_timer #(.CNT_W(CNT_W), .RST_VAL(RECALL_LD)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_store || start_recall),
    .load_val_i (start_store ? STORE_LD : RECALL_LD),
    .run_i      (busy),
    .zero_o     (zero)
  );

  assign finish = busy && zero;

  always_comb begin
    op_d = op_q;
    if (start_store)       op_d = OP_STORE;
    else if (start_recall) op_d = OP_RECALL;
    else if (finish)       op_d = OP_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= OP_RECALL;
      dirty_q   <= 1'b0;
      auto_en_q <= 1'b1;
      sdone_q   <= 1'b0;
      rdone_q   <= 1'b0;
    end else begin
      op_q    <= op_d;
      sdone_q <= finish && (op_q == OP_STORE);
      rdone_q <= finish && (op_q == OP_RECALL);
      if (finish)                dirty_q <= 1'b0;
      else if (fire && acc_we_i) dirty_q <= 1'b1;
      if (cmd == CMD_AUTO_OFF)     auto_en_q <= 1'b0;
      else if (cmd == CMD_AUTO_ON) auto_en_q <= 1'b1;
    end
  end

  assign acc_ok_o      = fire;
  assign busy_no       = !busy;
  assign store_done_o  = sdone_q;
  assign recall_done_o = rdone_q;
  assign dirty_o       = dirty_q;
  assign auto_en_o     = auto_en_q;
endmodule

// File: rtl/nvop_sequencer_chk.sv
`timescale 1ns/1ps
module nvop_sequencer_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              acc_we_i,
  input logic              hw_store_req_i,
  input logic              pwr_fail_i,
  input logic              acc_ok_o,
  input logic              busy_no,
  input logic              store_done_o,
  input logic              recall_done_o,
  input logic              dirty_o,
  input logic              auto_en_o
);
  logic unused_addr;
  assign unused_addr = ^acc_addr_i;

  // R9
  blocked_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_no |-> !acc_ok_o);

  // R6
  dirty_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok_o && acc_we_i |=> dirty_o);

  // R7
  clean_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_no && !dirty_o && !acc_ok_o |=> busy_no);

  // R8
  auto_off_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_no && !auto_en_o && !hw_store_req_i && !acc_ok_o |=> busy_no);

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_done_o || recall_done_o) |=> !(store_done_o || recall_done_o));

  // R11
  done_with_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_done_o || recall_done_o) |-> busy_no && $past(!busy_no));

  // R11
  done_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({store_done_o, recall_done_o}));

  // R6
  dirty_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_done_o || recall_done_o) |-> !dirty_o);
endmodule

bind nvop_sequencer nvop_sequencer_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_nvop_sequencer.sv
`timescale 1ns/1ps
module test_nvop_sequencer;
  localparam int ADDR_W = 15;
  localparam int ST_CYC = 40;
  localparam int RC_CYC = 24;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic acc_valid_i = 1'b0;
  logic [ADDR_W-1:0] acc_addr_i = '0;
  logic acc_we_i = 1'b0;
  logic hw_store_req_i = 1'b0;
  logic pwr_fail_i = 1'b0;
  logic acc_ok_o, busy_no, store_done_o, recall_done_o, dirty_o, auto_en_o;

  int checks = 0;
  int failures = 0;
  logic last_ok;

  always #2.5 clk_i = ~clk_i;

  nvop_sequencer #(.ADDR_W(ADDR_W), .STORE_CYCLES(ST_CYC), .RECALL_CYCLES(RC_CYC)) i_nvop_sequencer (
    .clk_i, .rst_ni, .acc_valid_i, .acc_addr_i, .acc_we_i, .hw_store_req_i, .pwr_fail_i,
    .acc_ok_o, .busy_no, .store_done_o, .recall_done_o, .dirty_o, .auto_en_o
  );

  logic [ADDR_W-1:0] keys [5] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F};

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_acc(input logic [ADDR_W-1:0] a, input logic we);
    @(negedge clk_i);
    acc_valid_i = 1'b1; acc_addr_i = a; acc_we_i = we;
    #1 last_ok = acc_ok_o;
    @(negedge clk_i);
    acc_valid_i = 1'b0; acc_we_i = 1'b0;
  endtask

  task automatic send_seq(input logic [ADDR_W-1:0] cmd_a, input logic [ADDR_W-1:0] hi);
    for (int i = 0; i < 5; i++) do_acc(keys[i] | hi, 1'b0);
    do_acc(cmd_a | hi, 1'b0);
  endtask

  task automatic measure_busy(output int n);
    n = 0;
    while (!busy_no && n < 1000) begin n++; @(negedge clk_i); end
  endtask

  task automatic idle_for(input int c);
    for (int i = 0; i < c; i++) @(negedge clk_i);
  endtask

  task automatic t_reset;
    int n;
    idle_for(3);
    chk(busy_no == 0, "R10 busy in reset", busy_no, 0);
    chk(auto_en_o == 1, "R8 auto_en at reset", auto_en_o, 1);
    chk(dirty_o == 0, "R6 dirty at reset", dirty_o, 0);
    rst_ni = 1'b1;
    measure_busy(n);
    chk(n == RC_CYC, "R10 power-up recall length", n, RC_CYC);
    chk(recall_done_o == 1 && store_done_o == 0, "R11 recall done pulse", recall_done_o, 1);
    @(negedge clk_i);
    chk(recall_done_o == 0, "R11 done one cycle", recall_done_o, 0);
  endtask

  task automatic t_sw_store_clean;
    int n;
    send_seq(15'h0FC0, '0);
    chk(busy_no == 0, "R4 store starts next cycle", busy_no, 0);
    measure_busy(n);
    chk(n == ST_CYC, "R4 store length unconditional", n, ST_CYC);
    chk(store_done_o == 1 && recall_done_o == 0, "R11 store done pulse", store_done_o, 1);
  endtask

  task automatic t_dirty_recall;
    int n;
    do_acc(15'h0123, 1'b1);
    chk(dirty_o == 1, "R6 write sets dirty", dirty_o, 1);
    send_seq(15'h0C63, '0);
    measure_busy(n);
    chk(n == RC_CYC, "R5 recall length", n, RC_CYC);
    chk(recall_done_o == 1, "R11 recall done", recall_done_o, 1);
    chk(dirty_o == 0, "R6 recall clears dirty", dirty_o, 0);
  endtask

  task automatic t_hw_store;
    int n;
    hw_store_req_i = 1'b1;
    idle_for(4);
    chk(busy_no == 1, "R7 clean hw request ignored", busy_no, 1);
    hw_store_req_i = 1'b0;
    do_acc(15'h0456, 1'b1);
    hw_store_req_i = 1'b1;
    @(negedge clk_i);
    hw_store_req_i = 1'b0;
    chk(busy_no == 0, "R7 dirty hw request stores", busy_no, 0);
    measure_busy(n);
    chk(n == ST_CYC, "R7 hw store length", n, ST_CYC);
    chk(dirty_o == 0 && store_done_o == 1, "R6 store clears dirty", dirty_o, 0);
  endtask

  task automatic t_aborts;
    for (int i = 0; i < 3; i++) do_acc(keys[i], 1'b0);
    do_acc(15'h0000, 1'b0);
    do_acc(keys[3], 1'b0); do_acc(keys[4], 1'b0); do_acc(15'h0FC0, 1'b0);
    idle_for(2);
    chk(busy_no == 1, "R2 foreign read aborts", busy_no, 1);
    for (int i = 0; i < 5; i++) do_acc(keys[i], 1'b0);
    do_acc(15'h0FC0, 1'b1);
    do_acc(15'h0FC0, 1'b0);
    idle_for(2);
    chk(busy_no == 1, "R2 write aborts", busy_no, 1);
    send_seq(15'h0FC1, '0);
    idle_for(2);
    chk(busy_no == 1 && auto_en_o == 1, "R2 unknown command code", busy_no, 1);
  endtask

  task automatic t_restart;
    int n;
    do_acc(keys[0], 1'b0); do_acc(keys[1], 1'b0);
    do_acc(keys[0], 1'b0);
    for (int i = 1; i < 5; i++) do_acc(keys[i], 1'b0);
    do_acc(15'h0FC0, 1'b0);
    chk(busy_no == 0, "R3 restart at step two", busy_no, 0);
    measure_busy(n);
    chk(n == ST_CYC, "R3 restarted store length", n, ST_CYC);
  endtask

  task automatic t_upper_bit;
    int n;
    send_seq(15'h0C63, 15'h4000);
    chk(busy_no == 0, "R1 bit 14 ignored", busy_no, 0);
    measure_busy(n);
    chk(n == RC_CYC && recall_done_o == 1, "R1 recall code decoded", n, RC_CYC);
  endtask

  task automatic t_auto;
    int n;
    send_seq(15'h0B45, '0);
    chk(auto_en_o == 0 && busy_no == 1, "R1 auto-off code", auto_en_o, 0);
    do_acc(15'h0789, 1'b1);
    pwr_fail_i = 1'b1;
    idle_for(4);
    chk(busy_no == 1, "R8 power fail ignored when disabled", busy_no, 1);
    pwr_fail_i = 1'b0;
    send_seq(15'h0B46, '0);
    chk(auto_en_o == 1 && busy_no == 1, "R1 auto-on code", auto_en_o, 1);
    pwr_fail_i = 1'b1;
    @(negedge clk_i);
    pwr_fail_i = 1'b0;
    chk(busy_no == 0, "R8 power fail stores when dirty", busy_no, 0);
    measure_busy(n);
    chk(n == ST_CYC, "R8 power fail store length", n, ST_CYC);
  endtask

  task automatic t_blocked;
    int n;
    send_seq(15'h0FC0, '0);
    do_acc(15'h0100, 1'b1);
    chk(last_ok == 0, "R9 access refused while busy", last_ok, 0);
    measure_busy(n);
    chk(dirty_o == 0, "R9 blocked write leaves dirty clear", dirty_o, 0);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_sw_store_clean();
    t_dirty_recall();
    t_hw_store();
    t_aborts();
    t_restart();
    t_upper_bit();
    t_auto();
    t_blocked();
    idle_for(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule